// File: doc/BRIEF.md
# Oversampled SPI Mode 0 Byte Slave

This block is a byte-wide SPI slave for SPI Mode 0 (clock idles low, data sampled on the rising clock edge) that runs entirely on the system clock. The serial clock, the active-low select and the serial input are not used as clocks. Each is treated as plain data and passes through its own two-stage synchronizer. Clock edges are found by comparing consecutive synchronized samples. A single state machine then shifts the incoming byte in, presents it on a held output register with a one-cycle strobe, and shifts a parallel transmit byte out on MISO.

The state machine has three states. ST_IDLE holds while the select is high. In ST_SHIFT the byte is being exchanged. ST_HOLD is entered once a byte has completed in the current select. The transitions are named as follows. SELECT (ST_IDLE to ST_SHIFT, on a low select) loads the transmit byte. COMPLETE (ST_SHIFT to ST_HOLD, on the eighth detected rising edge) publishes the byte. ABORT (ST_SHIFT to ST_IDLE, on a high select) drops a partial byte. RELEASE (ST_HOLD to ST_IDLE, on a high select) ends a finished transfer.

Because edges are found by oversampling, the serial clock must run below about a quarter of the system clock. Each serial clock level must last at least two system clock cycles.

Top module: `spi_os_slave`

## Requirements
- R1: After reset, rx_byte is 0x00, rx_strobe is low and miso_out is low.
- R2: While selected, the block samples mosi_in on each rising edge of sck_in. The first bit sampled is bit 7 of the byte. After eight such edges, rx_byte equals the byte sent.
- R3: rx_strobe is high for exactly one clk cycle for each completed byte. It rises within four clk cycles of the eighth rising edge of sck_in.
- R4: rx_byte changes only in a cycle where rx_strobe is high, and otherwise keeps its last value.
- R5: If ss_n_in goes high before eight bits have arrived, rx_strobe does not pulse and rx_byte is not updated. The next selection starts a new byte from bit 7.
- R6: While ss_n_in is high, miso_out is low.
- R7: When ss_n_in falls, the block samples tx_byte. Bit 7 of that sample appears on miso_out, and each later falling edge of sck_in advances to the next lower bit. Changes to tx_byte during the transfer have no effect.
- R8: Rising edges of sck_in after the eighth one in the same selection are ignored. They produce no further strobe and leave rx_byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_in | input | 1 | Serial clock, asynchronous |
| ss_n_in | input | 1 | Active-low slave select, asynchronous |
| mosi_in | input | 1 | Serial data from the master, asynchronous |
| tx_byte | input | 8 | Parallel byte to send, sampled when the select falls |
| miso_out | output | 1 | Serial data to the master |
| rx_byte | output | 8 | Last completely received byte |
| rx_strobe | output | 1 | One-cycle pulse when rx_byte takes a new byte |

## Verification
The assertions assume that every level of sck_in lasts at least two clk cycles. They also assume mosi_in is stable around each rising edge of sck_in, so that the synchronized data and clock samples line up, and that sck_in is low whenever ss_n_in changes. The stimulus meets these conditions with a master that holds each half period for eight clk cycles. It changes mosi_in only while sck_in is low and moves the select only with the clock idle. Its inputs are driven on the falling edge of clk.

// File: rtl/spi_os_pkg.sv
package spi_os_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } link_state_t;

endpackage

// File: rtl/spi_os_sync.sv
module spi_os_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    input  logic [WIDTH-1:0] rst_val,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= rst_val;
                else        chain[0] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= rst_val;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/spi_os_edge.sv
module spi_os_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);

    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;
    assign fall = ~level & level_q;

endmodule

// File: rtl/spi_os_ctrl.sv
module spi_os_ctrl
    import spi_os_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_hi,
    input  logic              din,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              miso,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_strobe,
    output link_state_t       state_o
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    link_state_t       state, next;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-2:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic              complete;

    assign complete = (state == ST_SHIFT) && !sel_hi && sck_rise && (bit_cnt == LAST_BIT);

    // next-state logic: SELECT, COMPLETE, ABORT, RELEASE
    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE:  if (!sel_hi)      next = ST_SHIFT;
            ST_SHIFT: if (sel_hi)       next = ST_IDLE;
                      else if (complete) next = ST_HOLD;
            ST_HOLD:  if (sel_hi)       next = ST_IDLE;
            default:                    next = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next;
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    bit_cnt <= '0;
                    if (!sel_hi) tx_sh <= tx_byte;
                end
                ST_SHIFT: begin
                    if (sel_hi) begin
                        bit_cnt <= '0;
                    end else begin
                        if (sck_rise) begin
                            rx_sh   <= {rx_sh[DATA_W-3:0], din};
                            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
                        end
                        if (sck_fall) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                    end
                end
                ST_HOLD:  bit_cnt <= '0;
                default:  bit_cnt <= '0;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_byte   <= '0;
            rx_strobe <= 1'b0;
        end else begin
            rx_strobe <= complete;
            if (complete) rx_byte <= {rx_sh, din};
        end
    end

    assign miso    = (state == ST_SHIFT) ? tx_sh[DATA_W-1] : 1'b0;
    assign state_o = state;

endmodule

// File: rtl/spi_os_slave.sv
module spi_os_slave
    import spi_os_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_in,
    input  logic              ss_n_in,
    input  logic              mosi_in,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              miso_out,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_strobe
);

    localparam int NSIG = 3;

    logic [NSIG-1:0] pins_sync;
    logic            sck_s, sel_s, din_s;
    logic            sck_rise, sck_fall;
    link_state_t     fsm_state;

    // sync order: {sck, select, data}; select resets high (deselected)
    spi_os_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sck_in, ss_n_in, mosi_in}),
        .rst_val  (3'b010),
        .sync_out (pins_sync)
    );

    assign {sck_s, sel_s, din_s} = pins_sync;

    spi_os_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sck_s),
        .rise  (sck_rise),
        .fall  (sck_fall)
    );

    spi_os_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_hi    (sel_s),
        .din       (din_s),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .tx_byte   (tx_byte),
        .miso      (miso_out),
        .rx_byte   (rx_byte),
        .rx_strobe (rx_strobe),
        .state_o   (fsm_state)
    );

endmodule

// File: rtl/spi_os_slave_chk.sv
module spi_os_slave_chk
    import spi_os_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_s,
    input logic [DATA_W-1:0] tx_byte,
    input logic              miso_out,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rx_strobe,
    input link_state_t       fsm_state
);

    // R3: strobe never lasts two cycles
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe);

    // R4: output byte moves only with the strobe
    a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_byte != $past(rx_byte)) |-> rx_strobe);

    // R5: a deselected cycle never yields a strobe
    a_r5_deselect_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> !rx_strobe);

    // R6: deselected means MISO low on the following cycle
    a_r6_idle_miso: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> !miso_out);

    // R7: first bit shown is the MSB of the byte sampled at selection
    a_r7_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && !sel_s) |=> (miso_out == $past(tx_byte[DATA_W-1])));

    // R8: after completion the machine holds until deselect
    a_r8_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_HOLD) |=> !rx_strobe);

endmodule

bind spi_os_slave spi_os_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_s     (sel_s),
    .tx_byte   (tx_byte),
    .miso_out  (miso_out),
    .rx_byte   (rx_byte),
    .rx_strobe (rx_strobe),
    .fsm_state (fsm_state)
);

// File: tb/spi_os_slave_test.sv
module spi_os_slave_test;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck_in = 1'b0;
    logic       ss_n_in = 1'b1;
    logic       mosi_in = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       miso_out;
    logic [7:0] rx_byte;
    logic       rx_strobe;

    int         tests = 0;
    int         fails = 0;
    logic [7:0] exp_q[$];
    logic [7:0] last_rx = 8'h00;
    logic       prev_strobe = 1'b0;
    int         since_rise = 0;
    int         rise_count = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    spi_os_slave uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_in    (sck_in),
        .ss_n_in   (ss_n_in),
        .mosi_in   (mosi_in),
        .tx_byte   (tx_byte),
        .miso_out  (miso_out),
        .rx_byte   (rx_byte),
        .rx_strobe (rx_strobe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("[TB] FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected bytes when the strobe appears
    always @(negedge clk) begin
        if (rst_n && !done) begin
            since_rise++;
            if (rx_strobe) begin
                if (prev_strobe) check(0, "R3 strobe longer than one cycle", 1, 0);
                if (exp_q.size() == 0) begin
                    check(0, "R5/R8 unexpected strobe", int'(rx_byte), int'(last_rx));
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(rx_byte == e, "R2 received byte", int'(rx_byte), int'(e));
                    check(since_rise <= 4, "R3 strobe latency", since_rise, 4);
                end
                last_rx = rx_byte;
            end else if (rx_byte != last_rx) begin
                check(0, "R4 byte changed without strobe", int'(rx_byte), int'(last_rx));
                last_rx = rx_byte;
            end
            prev_strobe = rx_strobe;
        end
    end

    // driver: one selection with nbits clocks; pushes expectation if full byte
    task automatic xfer(input logic [7:0] mo, input logic [7:0] tx, input int nbits);
        if (nbits >= 8) exp_q.push_back(mo);
        tx_byte = tx;
        @(negedge clk);
        ss_n_in = 1'b0;
        repeat (HALF) @(negedge clk);
        tx_byte = ~tx;  // R7: later changes must be ignored
        for (int i = 0; i < nbits; i++) begin
            mosi_in = (i < 8) ? mo[7-i] : 1'b1;
            repeat (HALF) @(negedge clk);
            if (i < 8) check(miso_out == tx[7-i], "R7 MISO bit", int'(miso_out), int'(tx[7-i]));
            sck_in = 1'b1;
            if (i == 7) since_rise = -1;
            rise_count++;
            repeat (HALF) @(negedge clk);
            sck_in = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        ss_n_in = 1'b1;
        repeat (4) @(negedge clk);
        check(miso_out == 1'b0, "R6 MISO idle after deselect", int'(miso_out), 0);
        repeat (HALF) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(rx_byte == 8'h00, "R1 reset rx_byte", int'(rx_byte), 0);
        check(rx_strobe == 1'b0, "R1 reset strobe", int'(rx_strobe), 0);
        check(miso_out == 1'b0, "R1 reset MISO", int'(miso_out), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(miso_out == 1'b0, "R6 MISO idle before select", int'(miso_out), 0);

        xfer(8'hA5, 8'h3C, 8);   // R2 R7
        xfer(8'h3C, 8'hA5, 8);
        xfer(8'h00, 8'hFF, 8);
        xfer(8'hFF, 8'h00, 8);
        xfer(8'h81, 8'h96, 8);

        // R5: aborted partial byte leaves the output alone
        xfer(8'h7E, 8'h55, 5);
        check(rx_byte == 8'h81, "R5 abort keeps rx_byte", int'(rx_byte), 8'h81);
        xfer(8'h5A, 8'hC3, 8);   // R5 next byte starts from bit 7

        // R8: extra clocks after the eighth are ignored
        xfer(8'h42, 8'h18, 11);
        check(rx_byte == 8'h42, "R8 extra clocks leave rx_byte", int'(rx_byte), 8'h42);
        // R4: output held across idle time
        repeat (20) @(negedge clk);
        check(rx_byte == 8'h42, "R4 rx_byte held while idle", int'(rx_byte), 8'h42);

        check(exp_q.size() == 0, "R2 all bytes delivered", exp_q.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("[TB] FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule